// File: doc/BRIEF.md
# Luma extractor and word packer for a camera byte stream

This block sits between a camera sensor port and a DMA write engine. The sensor sends interleaved YCbCr 4:2:2 bytes, one per cycle when `pix_valid` is high. Sync flags travel with the bytes: a frame-start flag marks the first byte of a frame, a line-start flag marks the first byte of each line, and a frame-end flag marks the final byte of the frame. The block throws away the two chroma bytes of every four-byte group. It gathers the luminance bytes four at a time into 32-bit words and queues them in a small FIFO. The output is a valid/ready stream, and the DMA engine drains it into a frame buffer.

Software controls the capture with a one-cycle request pulse, which arms the block for a single frame. Capture begins at the next frame-start byte, so a frame that was already in progress is never written in part. When the final word of the frame has been taken by the consumer, a done flag rises. It stays up until the next request. If the FIFO has no room for a packed word, that word is lost and a sticky overflow flag is set.

Top module: `luma_packer`

## Requirements
- R1: After reset, `cap_busy`, `cap_done`, `cap_ovf` and `m_valid` are all 0.
- R2: Each group of four bytes counted from a line start has the order Cb, Y0, Cr, Y1. Only the bytes at positions 1 and 3 (Y0 and Y1) reach the output; the chroma bytes at positions 0 and 2 never appear in any word.
- R3: Luma bytes fill each word from the low end. The earliest byte goes to bits [7:0], the next to [15:8], then [23:16], then [31:24].
- R4: A request arms the block, and capture begins with the first byte that has `pix_sof` set. Bytes received while armed but before that byte produce no words.
- R5: A byte with `pix_sol` set resets the byte position to 0 (Cb). A line whose byte count is not a multiple of four therefore does not shift the luma selection of the following line.
- R6: The byte that carries `pix_eof` closes the frame. The word that holds the frame's final luma bytes leaves with `m_last`=1, and any lanes above those bytes are zero.
- R7: `cap_done` rises only after the consumer accepts the `m_last` word (`m_valid` and `m_ready` both high). It does not rise while that word is still waiting.
- R8: A request accepted while idle clears `cap_done` and `cap_ovf` on the next cycle and raises `cap_busy`. A request made while `cap_busy` is 1 is ignored, and the frame in progress completes unchanged.
- R9: A packed word that finds the FIFO full is discarded and `cap_ovf` is set. `cap_ovf` stays set until the next accepted request. The words already queued still come out in order. If the discarded word was the final one, `cap_done` rises once the FIFO has drained.
- R10: While `m_valid` is 1 and `m_ready` is 0, `m_valid`, `m_data` and `m_last` hold their values.
- R11: While no capture is armed or running, input bytes produce no output words (`m_valid` stays 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Input byte present this cycle |
| pix_data | input | 8 | Input byte (Cb, Y0, Cr, Y1 order) |
| pix_sof | input | 1 | Byte is the first of a frame |
| pix_sol | input | 1 | Byte is the first of a line |
| pix_eof | input | 1 | Byte is the last of a frame |
| cap_req | input | 1 | One-cycle request to capture the next frame |
| cap_busy | output | 1 | Capture armed, running or draining |
| cap_done | output | 1 | Last word of the frame was accepted |
| cap_ovf | output | 1 | Sticky: a word was lost to a full FIFO |
| m_valid | output | 1 | Output word available |
| m_ready | input | 1 | Consumer accepts the word |
| m_data | output | 32 | Packed luma word |
| m_last | output | 1 | Word is the final one of the frame |

## Verification
The hardest situation to reach is an overflow that swallows the final word of the frame. In that case the done flag has to come from the FIFO draining, because no `m_last` handshake ever happens. The bench reaches it by holding `m_ready` low through a whole frame that produces more words than the FIFO can hold. It then releases the consumer and checks that exactly the first FIFO-depth words come out, that none of them is marked last, and that done follows the drain. A second hard case is a line with an odd byte count, which is the only way to show that the line-start flag realigns the byte position.

// File: rtl/luma_pkg.sv
package luma_pkg;
  parameter int PIX_W   = 8;
  parameter int LANES   = 4;
  parameter int WORD_W  = PIX_W * LANES;
  parameter int LANE_IW = $clog2(LANES);
  parameter int PHASE_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_GRAB  = 2'd2,
    ST_DRAIN = 2'd3
  } cap_state_t;

  // Byte position within a Cb,Y0,Cr,Y1 group: odd positions carry luma.
  function automatic logic is_luma_slot(input logic [PHASE_W-1:0] ph);
    return ph[0];
  endfunction

  // Place one byte into lane `lane` of a word, lane 0 at the low end.
  function automatic logic [WORD_W-1:0] put_lane(input logic [WORD_W-1:0] w,
                                                 input logic [LANE_IW-1:0] lane,
                                                 input logic [PIX_W-1:0] b);
    logic [WORD_W-1:0] r;
    r = w;
    r[int'(lane)*PIX_W +: PIX_W] = b;
    return r;
  endfunction
endpackage

// File: rtl/luma_lane_packer.sv
module luma_lane_packer
  import luma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [PIX_W-1:0]  pix_data,
  input  logic              pix_sof,
  input  logic              pix_sol,
  input  logic              pix_eof,
  output logic              w_valid,
  output logic [WORD_W-1:0] w_data,
  output logic              w_last
);
  logic [PHASE_W-1:0] phase_q, ph;
  logic [LANE_IW-1:0] lane_q, base_lane;
  logic [WORD_W-1:0]  acc_q, base_acc, acc_n;
  logic               keep, lane_full, emit;

  always_comb begin
    ph        = (pix_sof || pix_sol) ? '0 : phase_q;
    keep      = is_luma_slot(ph);
    base_acc  = pix_sof ? '0 : acc_q;
    base_lane = pix_sof ? '0 : lane_q;
    acc_n     = keep ? put_lane(base_acc, base_lane, pix_data) : base_acc;
    lane_full = keep && (base_lane == LANE_IW'(LANES - 1));
    emit      = lane_full || pix_eof;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      lane_q  <= '0;
      acc_q   <= '0;
      w_valid <= 1'b0;
      w_data  <= '0;
      w_last  <= 1'b0;
    end else if (take) begin
      phase_q <= ph + 1'b1;
      w_valid <= emit;
      w_data  <= acc_n;
      w_last  <= pix_eof;
      if (emit) begin
        acc_q  <= '0;
        lane_q <= '0;
      end else begin
        acc_q  <= acc_n;
        lane_q <= keep ? base_lane + 1'b1 : base_lane;
      end
    end else begin
      w_valid <= 1'b0;
      w_last  <= 1'b0;
    end
  end
endmodule

// File: rtl/word_fifo.sv
module word_fifo #(
  parameter int W     = 33,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/capture_fsm.sv
module capture_fsm
  import luma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cap_req,
  input  logic pix_valid,
  input  logic pix_sof,
  input  logic pix_eof,
  input  logic last_pop,
  input  logic word_drop,
  input  logic last_lost,
  input  logic fifo_empty,
  output logic take,
  output logic cap_busy,
  output logic cap_done,
  output logic cap_ovf
);
  cap_state_t st_q, st_n;
  logic       lost_q, req_ok, finish;

  assign req_ok   = cap_req && (st_q == ST_IDLE);
  assign take     = pix_valid && (((st_q == ST_ARMED) && pix_sof) || (st_q == ST_GRAB));
  assign finish   = (st_q == ST_DRAIN) && (last_pop || (lost_q && fifo_empty));
  assign cap_busy = (st_q != ST_IDLE);

  always_comb begin
    st_n = st_q;
    case (st_q)
      ST_IDLE:  if (req_ok) st_n = ST_ARMED;
      ST_ARMED: if (pix_valid && pix_sof) st_n = pix_eof ? ST_DRAIN : ST_GRAB;
      ST_GRAB:  if (pix_valid && pix_eof) st_n = ST_DRAIN;
      ST_DRAIN: if (finish) st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      lost_q   <= 1'b0;
      cap_done <= 1'b0;
      cap_ovf  <= 1'b0;
    end else begin
      st_q <= st_n;
      if (finish)         lost_q <= 1'b0;
      else if (last_lost) lost_q <= 1'b1;
      if (req_ok)      cap_done <= 1'b0;
      else if (finish) cap_done <= 1'b1;
      if (word_drop)   cap_ovf <= 1'b1;
      else if (req_ok) cap_ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/luma_packer.sv
module luma_packer
  import luma_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_data,
  input  logic              pix_sof,
  input  logic              pix_sol,
  input  logic              pix_eof,
  input  logic              cap_req,
  output logic              cap_busy,
  output logic              cap_done,
  output logic              cap_ovf,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [WORD_W-1:0] m_data,
  output logic              m_last
);
  logic              take;
  logic              w_valid, w_last;
  logic [WORD_W-1:0] w_data;
  logic              fifo_empty, fifo_full;
  logic [WORD_W:0]   fifo_out;

  // Named events shared with the checker.
  logic word_push, word_drop, last_pop, last_lost;

  assign word_push = w_valid && !fifo_full;
  assign word_drop = w_valid && fifo_full;
  assign last_lost = word_drop && w_last;
  assign m_valid   = !fifo_empty;
  assign m_data    = fifo_out[WORD_W-1:0];
  assign m_last    = fifo_out[WORD_W];
  assign last_pop  = m_valid && m_ready && m_last;

  capture_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_req    (cap_req),
    .pix_valid  (pix_valid),
    .pix_sof    (pix_sof),
    .pix_eof    (pix_eof),
    .last_pop   (last_pop),
    .word_drop  (word_drop),
    .last_lost  (last_lost),
    .fifo_empty (fifo_empty),
    .take       (take),
    .cap_busy   (cap_busy),
    .cap_done   (cap_done),
    .cap_ovf    (cap_ovf)
  );

  luma_lane_packer u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .pix_data (pix_data),
    .pix_sof  (pix_sof),
    .pix_sol  (pix_sol),
    .pix_eof  (pix_eof),
    .w_valid  (w_valid),
    .w_data   (w_data),
    .w_last   (w_last)
  );

  word_fifo #(.W(WORD_W + 1), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (word_push),
    .din   ({w_last, w_data}),
    .pop   (m_valid && m_ready),
    .dout  (fifo_out),
    .empty (fifo_empty),
    .full  (fifo_full)
  );
endmodule

// File: rtl/luma_packer_checker.sv
module luma_packer_checker
  import luma_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cap_req,
  input logic              cap_busy,
  input logic              cap_done,
  input logic              cap_ovf,
  input logic              m_valid,
  input logic              m_ready,
  input logic [WORD_W-1:0] m_data,
  input logic              m_last,
  input logic              last_pop,
  input logic              word_drop
);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_last));

  p_done_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done && !$past(cap_done) |-> $past(last_pop) || !$past(m_valid));

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ovf && !cap_req |=> cap_ovf);

  p_drop_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    word_drop |=> cap_ovf);

  p_req_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_req && !cap_busy |=> !cap_done && !cap_ovf && cap_busy);

  p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_busy |-> !m_valid);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |-> !cap_busy);
endmodule

bind luma_packer luma_packer_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cap_req   (cap_req),
  .cap_busy  (cap_busy),
  .cap_done  (cap_done),
  .cap_ovf   (cap_ovf),
  .m_valid   (m_valid),
  .m_ready   (m_ready),
  .m_data    (m_data),
  .m_last    (m_last),
  .last_pop  (last_pop),
  .word_drop (word_drop)
);

// File: tb/luma_packer_bench.sv
module luma_packer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_data = '0;
  logic        pix_sof = 1'b0, pix_sol = 1'b0, pix_eof = 1'b0;
  logic        cap_req = 1'b0;
  logic        cap_busy, cap_done, cap_ovf;
  logic        m_valid, m_last;
  logic        m_ready = 1'b1;
  logic [31:0] m_data;

  int n_checks = 0;
  int n_fails  = 0;
  logic [7:0]  exp_q[$];
  logic [32:0] got_q[$];
  logic [7:0]  seed;
  bit          expect_cap;

  always #4 clk = ~clk;

  luma_packer u_luma_packer (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_sof(pix_sof), .pix_sol(pix_sol), .pix_eof(pix_eof), .cap_req(cap_req),
    .cap_busy(cap_busy), .cap_done(cap_done), .cap_ovf(cap_ovf),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last)
  );

  always @(posedge clk)
    if (rst_n && m_valid && m_ready) got_q.push_back({m_last, m_data});

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b, input bit sof, input bit sol, input bit eof);
    pix_valid = 1'b1; pix_data = b; pix_sof = sof; pix_sol = sol; pix_eof = eof;
    @(negedge clk);
    pix_valid = 1'b0; pix_sof = 1'b0; pix_sol = 1'b0; pix_eof = 1'b0;
  endtask

  // One line; byte positions count from the line start (Cb, Y0, Cr, Y1).
  task automatic send_line(input int nbytes, input bit first, input bit last_line);
    for (int p = 0; p < nbytes; p++) begin
      logic [7:0] b;
      if (p % 2 == 1) begin
        b = seed; seed = seed + 8'd1;
        if (expect_cap) exp_q.push_back(b);
      end else begin
        b = 8'hE0 | 8'(p % 16);
      end
      put(b, first && p == 0, p == 0, last_line && p == nbytes - 1);
    end
  endtask

  task automatic send_frame(input int nlines, input int bpl);
    for (int l = 0; l < nlines; l++) send_line(bpl, l == 0, l == nlines - 1);
  endtask

  task automatic request();
    cap_req = 1'b1;
    @(negedge clk);
    cap_req = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!cap_done && n < 2000) begin @(negedge clk); n++; end
    chk(cap_done, req, "done after frame", 64'(cap_done), 64'd1);
  endtask

  task automatic check_words(input string req, input int nwant, input bit want_last);
    chk(got_q.size() == nwant, req, "word count", 64'(got_q.size()), 64'(nwant));
    for (int i = 0; i < nwant && i < got_q.size(); i++) begin
      logic [32:0] w = '0;
      for (int k = 0; k < 4; k++) begin
        int idx = i * 4 + k;
        if (idx < exp_q.size()) w[k*8 +: 8] = exp_q[idx];
      end
      w[32] = want_last && (i == nwant - 1);
      chk(got_q[i] == w, req, $sformatf("word %0d {last,data}", i), 64'(got_q[i]), 64'(w));
    end
  endtask

  task automatic start_test(input logic [7:0] s);
    got_q.delete(); exp_q.delete(); seed = s; expect_cap = 1'b1;
  endtask

  task automatic t_reset();
    chk(!cap_busy && !cap_done && !cap_ovf && !m_valid, "R1", "reset outputs",
        {60'd0, cap_busy, cap_done, cap_ovf, m_valid}, 64'd0);
  endtask

  task automatic t_basic();
    start_test(8'h10);
    request();
    chk(cap_busy, "R8", "busy after request", 64'(cap_busy), 64'd1);
    send_frame(2, 8);
    wait_done("R7");
    check_words("R2_R3_R6", 2, 1'b1);
  endtask

  task automatic t_no_request_and_pre_sof();
    start_test(8'h30);
    expect_cap = 1'b0;
    send_frame(1, 8);
    repeat (6) @(negedge clk);
    chk(got_q.size() == 0 && !m_valid, "R11", "no words without request",
        64'(got_q.size()), 64'd0);
    request();
    send_line(6, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    chk(got_q.size() == 0, "R4", "no words before frame start", 64'(got_q.size()), 64'd0);
    expect_cap = 1'b1;
    send_frame(1, 8);
    wait_done("R4");
    check_words("R4", 1, 1'b1);
  endtask

  task automatic t_realign();
    start_test(8'h50);
    request();
    send_line(5, 1'b1, 1'b0);
    send_line(8, 1'b0, 1'b1);
    wait_done("R5");
    check_words("R5_R6", 2, 1'b1);
  endtask

  task automatic t_backpressure();
    logic [31:0] held;
    start_test(8'h70);
    m_ready = 1'b0;
    request();
    send_frame(2, 8);
    request();
    repeat (8) @(negedge clk);
    chk(!cap_done, "R7", "done held while last word waits", 64'(cap_done), 64'd0);
    chk(m_valid, "R10", "word presented", 64'(m_valid), 64'd1);
    chk(cap_busy, "R8", "request while busy ignored", 64'(cap_busy), 64'd1);
    held = m_data;
    repeat (3) @(negedge clk);
    chk(m_data == held && m_valid, "R10", "data stable under stall", 64'(m_data), 64'(held));
    m_ready = 1'b1;
    wait_done("R7");
    check_words("R8", 2, 1'b1);
  endtask

  task automatic t_done_clear();
    start_test(8'h90);
    request();
    chk(!cap_done, "R8", "request clears done", 64'(cap_done), 64'd0);
    send_frame(1, 8);
    wait_done("R8");
    check_words("R3", 1, 1'b1);
  endtask

  task automatic t_overflow();
    start_test(8'h20);
    m_ready = 1'b0;
    request();
    send_frame(12, 8);
    repeat (4) @(negedge clk);
    chk(cap_ovf, "R9", "overflow flag set", 64'(cap_ovf), 64'd1);
    chk(!cap_done, "R9", "not done before drain", 64'(cap_done), 64'd0);
    m_ready = 1'b1;
    wait_done("R9");
    check_words("R9", 8, 1'b0);
    chk(cap_ovf, "R9", "overflow sticky after drain", 64'(cap_ovf), 64'd1);
    start_test(8'hA0);
    request();
    chk(!cap_ovf, "R8", "request clears overflow", 64'(cap_ovf), 64'd0);
    send_frame(1, 8);
    wait_done("R8");
    check_words("R8", 1, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_no_request_and_pre_sof();
    t_realign();
    t_backpressure();
    t_done_clear();
    t_overflow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    #1000000;
    n_checks++; n_fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule